// File: doc/BRIEF.md
# Touch Controller Serial Command Sequencer

This block is the digital half of a serial port on a resistive touch-screen converter. It runs on the serial clock `dclk`. Each transfer is framed by the active-low select `cs_n`. While select is low, the block waits for the first high bit on `din`. That bit starts a frame, and the next seven bits form a command. The command picks one of eight input channels, 12-bit or 8-bit resolution, single-ended or ratiometric reference, and two power-down bits. The decoded fields go out to neighbouring analog-control logic on `ch_sel`, `short_res`, `single_ended`, `pwr_sel` and `ref_diff`.

Each frame follows a fixed schedule of clock edges, counted from the rising edge that samples the start bit (edge 1):

- `acq_active` marks the three-period acquisition window that opens at falling edge 5.
- At falling edge 8 a behavioural successive-approximation model holds the input code `ain_code`.
- `busy` is high for exactly one period.
- The result leaves MSB first on `dout`, starting at falling edge 9.

A new start bit may arrive as soon as the previous command byte is complete. The previous result keeps shifting out while the new command is captured, so a 16-clock frame rate is possible. Raising `cs_n` ends any frame at once.

The receiver runs on rising edges and has two states:

- `RX_HUNT` waits for a start bit. It moves to `RX_BITS` when `din` is high.
- `RX_BITS` collects the command. It returns to `RX_HUNT` after the eighth bit, or whenever select is high.

The output sequencer runs on falling edges and has four states:

- `TX_IDLE` moves to `TX_BUSY` when a command completes.
- `TX_BUSY` moves to `TX_SHIFT` after emitting the MSB.
- `TX_SHIFT` moves to `TX_TAIL` after the last result bit.
- `TX_TAIL` holds `dout` low until the next command.

Select high forces both state machines back to their idle states. A completed command forces `TX_BUSY` from any state.

Top module: `tsc_serial_seq`

## Requirements
- R1: After `rst_n` is asserted, `busy`, `dout`, `acq_active`, `ref_diff` and all reported command fields are 0. While `cs_n` is high, `dout_en` and `busy_en` are 0.
- R2: While `cs_n` is high, `dout_en` and `busy_en` stay 0. Activity on `din` and `dclk` neither changes the reported fields nor starts a conversion. While `cs_n` is low, both enables are 1.
- R3: Zeros on `din` before the first 1 are ignored. The first 1 sampled on a rising edge with `cs_n` low is the start bit. The next seven rising edges capture, in this order: channel bit 2, channel bit 1, channel bit 0, resolution select, reference select, power bit 1, power bit 0.
- R4: The captured fields appear on `ch_sel`, `short_res`, `single_ended` and `pwr_sel` right after rising edge 8. They hold until the next command completes. Channel codes are: 000 temperature 0, 001 Y position, 010 battery, 011 Z1, 100 Z2, 101 X position, 110 auxiliary, 111 temperature 1.
- R5: `ref_diff` is 1 only when the reference bit is 0 and the channel code is 001, 011, 100 or 101. Otherwise it is 0.
- R6: `acq_active` rises at falling edge 5 and falls at falling edge 8, so it spans three clock periods.
- R7: `busy` rises at falling edge 8 and falls at falling edge 9. It is never high for two consecutive falling edges.
- R8: With resolution select 0, the 12 result bits leave MSB first on falling edges 9 to 20. After that `dout` is 0 until the next result.
- R9: With resolution select 1, only the upper 8 result bits leave, on falling edges 9 to 16. After that `dout` is 0.
- R10: The result equals the value of `ain_code` at falling edge 8. Later changes of `ain_code` do not affect it.
- R11: A 1 on `din` at any rising edge after a command completes starts a new frame. The earlier result continues unchanged, which allows frames every 16 clocks.
- R12: On the first falling edge with `cs_n` high, `busy`, `dout` and `acq_active` return to 0, and a partly received command is discarded. Lowering `cs_n` again with `din` low starts nothing, and the fields keep their last completed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Serial clock: command sampled on rising edges, result driven on falling edges |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial command input |
| ain_code | input | 12 | Digital stand-in for the sampled analog level |
| dout | output | 1 | Serial result, MSB first |
| dout_en | output | 1 | Drive enable for `dout` (0 means high impedance) |
| busy | output | 1 | Conversion-in-progress flag |
| busy_en | output | 1 | Drive enable for `busy` |
| acq_active | output | 1 | Acquisition window for the sample-and-hold |
| ch_sel | output | 3 | Decoded channel code |
| short_res | output | 1 | 1 selects 8-bit, 0 selects 12-bit |
| single_ended | output | 1 | Reference select as received (1 means single-ended) |
| pwr_sel | output | 2 | Power-down bits as received |
| ref_diff | output | 1 | Ratiometric reference actually in use |

## Verification
All timing is counted from the rising edge that samples the start bit, called edge 1:

- Command fields are due right after rising edge 8.
- `acq_active` is due after falling edges 5, 6 and 7.
- `busy` is due after falling edge 8 only.
- Result bit k, counted from the MSB as k = 0, is due after falling edge 9+k.

The bench drives inputs two time units after each falling edge. It samples every output at that same point, so each sample sees the state left by exactly one rising and one falling edge. Expected waveforms are built from the same edge arithmetic for every command byte, in both overlapped and spaced frames.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        CH_TEMP0 = 3'b000,
        CH_YPOS  = 3'b001,
        CH_BATT  = 3'b010,
        CH_Z1    = 3'b011,
        CH_Z2    = 3'b100,
        CH_XPOS  = 3'b101,
        CH_AUX   = 3'b110,
        CH_TEMP1 = 3'b111
    } chan_e;

    // Command fields after the start bit, in arrival order (first field = MSB).
    typedef struct packed {
        logic [2:0] chan;
        logic       short_res;
        logic       single_ended;
        logic [1:0] pwr;
    } cmd_t;

    localparam int CMD_BITS = $bits(cmd_t) + 1;

    typedef enum logic [0:0] {
        RX_HUNT,
        RX_BITS
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_BUSY,
        TX_SHIFT,
        TX_TAIL
    } tx_state_e;

    // Channels measured across a resistive plate pair.
    function automatic logic chan_is_plate(input logic [2:0] c);
        logic hit;
        unique case (chan_e'(c))
            CH_YPOS, CH_Z1, CH_Z2, CH_XPOS: hit = 1'b1;
            default:                        hit = 1'b0;
        endcase
        return hit;
    endfunction
endpackage

// File: rtl/tsc_cmd_rx.sv
module tsc_cmd_rx
    import tsc_pkg::*;
#(
    parameter int ACQ_EDGE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic din,
    output cmd_t cmd,
    output logic ref_diff,
    output logic byte_done,
    output logic acq_pos
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = $clog2(CMD_BITS);
    localparam int SW = CMD_BITS - 1;

    rx_state_e      st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [SW-1:0]  shreg_q;
    logic [SW-1:0]  full_w;
    cmd_t           cmd_q;
    logic           diff_q;
    logic           done_q;
    logic           last_bit;
    logic           taking;

    assign last_bit = (st_q == RX_BITS) && (cnt_q == CW'(CMD_BITS - 1));
    assign taking   = !cs_n && (st_q == RX_BITS);
    assign full_w   = {shreg_q[SW-2:0], din};

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (cs_n) begin
            st_d  = RX_HUNT;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                RX_HUNT: begin
                    if (din) begin
                        st_d  = RX_BITS;
                        cnt_d = CW'(1);
                    end
                end
                RX_BITS: begin
                    if (last_bit) begin
                        st_d  = RX_HUNT;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RX_HUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs: shift register, captured command, completion strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cmd_q   <= '0;
            diff_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cs_n) begin
                shreg_q <= '0;
            end else if (taking) begin
                shreg_q <= full_w;
                if (last_bit) begin
                    cmd_q  <= cmd_t'(full_w);
                    diff_q <= !full_w[$bits(cmd_t)-5] && chan_is_plate(full_w[SW-1:SW-3]);
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign cmd       = cmd_q;
    assign ref_diff  = diff_q;
    assign byte_done = done_q;
    assign acq_pos   = (st_q == RX_BITS) && (cnt_q == CW'(ACQ_EDGE));

    AST_CS_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(cmd_q) && $stable(diff_q)) else $error("fields moved while deselected"); // R2

    AST_DONE_AFTER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(st_q == RX_BITS)) else $error("command completed without capture"); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q) else $error("completion strobe held"); // R11
endmodule

// File: rtl/tsc_sar_model.sv
module tsc_sar_model #(
    parameter int RES_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     step,
    input  logic [$clog2(RES_W)-1:0] idx,
    input  logic [RES_W-1:0]         ain,
    output logic                     decide
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [RES_W-1:0] samp_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] trial;

    // Trial word: bits already decided plus the bit under test.
    always_comb begin
        trial  = acc_q | (RES_W'(1) << idx);
        decide = (samp_q >= trial);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
            acc_q  <= '0;
        end else if (load) begin
            samp_q <= ain;
            acc_q  <= '0;
        end else if (step && decide) begin
            acc_q  <= trial;
        end
    end
endmodule

// File: rtl/tsc_out_seq.sv
module tsc_out_seq
    import tsc_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int SHORT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     acq_pos,
    input  logic                     byte_done,
    input  logic                     short_res,
    input  logic                     decide,
    output logic                     sar_load,
    output logic                     sar_step,
    output logic [$clog2(RES_W)-1:0] sar_idx,
    output logic                     dout,
    output logic                     busy,
    output logic                     acq_active
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IW         = $clog2(RES_W);
    localparam int LAST_FULL  = 0;
    localparam int LAST_SHORT = RES_W - SHORT_W;

    tx_state_e     st_q, st_d;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] last_q;
    logic          dout_q;
    logic          busy_q;
    logic          acq_q;
    logic          shifting;

    assign shifting = (st_q == TX_BUSY) || (st_q == TX_SHIFT);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = TX_IDLE;
        end else if (byte_done) begin
            st_d = TX_BUSY;
        end else begin
            unique case (st_q)
                TX_IDLE:  st_d = TX_IDLE;
                TX_BUSY:  st_d = (idx_q == last_q) ? TX_TAIL : TX_SHIFT;
                TX_SHIFT: st_d = (idx_q == last_q) ? TX_TAIL : TX_SHIFT;
                TX_TAIL:  st_d = TX_TAIL;
            endcase
        end
    end

    // State register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // Outputs
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
            busy_q <= 1'b0;
            acq_q  <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (cs_n) begin
            dout_q <= 1'b0;
            busy_q <= 1'b0;
            acq_q  <= 1'b0;
            idx_q  <= '0;
        end else if (byte_done) begin
            busy_q <= 1'b1;
            acq_q  <= 1'b0;
            dout_q <= 1'b0;
            idx_q  <= IW'(RES_W - 1);
            last_q <= short_res ? IW'(LAST_SHORT) : IW'(LAST_FULL);
        end else begin
            busy_q <= 1'b0;
            if (acq_pos) acq_q <= 1'b1;
            unique case (st_q)
                TX_BUSY, TX_SHIFT: begin
                    dout_q <= decide;
                    idx_q  <= idx_q - IW'(1);
                end
                TX_IDLE, TX_TAIL: dout_q <= 1'b0;
            endcase
        end
    end

    assign sar_load   = !cs_n && byte_done;
    assign sar_step   = !cs_n && !byte_done && shifting;
    assign sar_idx    = idx_q;
    assign dout       = dout_q;
    assign busy       = busy_q;
    assign acq_active = acq_q;

    AST_BUSY_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        busy_q |=> !busy_q) else $error("busy longer than one period"); // R7

    AST_BUSY_AFTER_ACQ: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(acq_q)) else $error("busy without acquisition"); // R6

    AST_CS_QUIETS: assert property (@(negedge clk) disable iff (!rst_n)
        cs_n |=> (!busy_q && !dout_q && !acq_q)) else $error("outputs active after deselect"); // R12
endmodule

// File: rtl/tsc_serial_seq.sv
module tsc_serial_seq
    import tsc_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int SHORT_W  = 8,
    parameter int ACQ_EDGE = 5
) (
    input  logic             rst_n,
    input  logic             dclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic [RES_W-1:0] ain_code,
    output logic             dout,
    output logic             dout_en,
    output logic             busy,
    output logic             busy_en,
    output logic             acq_active,
    output logic [2:0]       ch_sel,
    output logic             short_res,
    output logic             single_ended,
    output logic [1:0]       pwr_sel,
    output logic             ref_diff
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IW = $clog2(RES_W);

    cmd_t          cmd_w;
    logic          byte_done_w;
    logic          acq_pos_w;
    logic          decide_w;
    logic          sar_load_w;
    logic          sar_step_w;
    logic [IW-1:0] sar_idx_w;

    tsc_cmd_rx #(
        .ACQ_EDGE (ACQ_EDGE)
    ) u_rx (
        .clk       (dclk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .din       (din),
        .cmd       (cmd_w),
        .ref_diff  (ref_diff),
        .byte_done (byte_done_w),
        .acq_pos   (acq_pos_w)
    );

    tsc_sar_model #(
        .RES_W (RES_W)
    ) u_sar (
        .clk    (dclk),
        .rst_n  (rst_n),
        .load   (sar_load_w),
        .step   (sar_step_w),
        .idx    (sar_idx_w),
        .ain    (ain_code),
        .decide (decide_w)
    );

    tsc_out_seq #(
        .RES_W   (RES_W),
        .SHORT_W (SHORT_W)
    ) u_tx (
        .clk        (dclk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .acq_pos    (acq_pos_w),
        .byte_done  (byte_done_w),
        .short_res  (cmd_w.short_res),
        .decide     (decide_w),
        .sar_load   (sar_load_w),
        .sar_step   (sar_step_w),
        .sar_idx    (sar_idx_w),
        .dout       (dout),
        .busy       (busy),
        .acq_active (acq_active)
    );

    assign dout_en      = !cs_n;
    assign busy_en      = !cs_n;
    assign ch_sel       = cmd_w.chan;
    assign short_res    = cmd_w.short_res;
    assign single_ended = cmd_w.single_ended;
    assign pwr_sel      = cmd_w.pwr;
endmodule

// File: tb/sim_tsc_serial_seq.sv
module sim_tsc_serial_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NF   = 128;
    localparam int MAXS = 4096;

    logic        rst_n = 1'b0;
    logic        dclk  = 1'b0;
    logic        cs_n  = 1'b1;
    logic        din   = 1'b0;
    logic [11:0] ain   = '0;
    logic        dout, dout_en, busy, busy_en, acq_active;
    logic [2:0]  ch_sel;
    logic        short_res, single_ended, ref_diff;
    logic [1:0]  pwr_sel;

    tsc_serial_seq u0 (
        .rst_n(rst_n), .dclk(dclk), .cs_n(cs_n), .din(din), .ain_code(ain),
        .dout(dout), .dout_en(dout_en), .busy(busy), .busy_en(busy_en),
        .acq_active(acq_active), .ch_sel(ch_sel), .short_res(short_res),
        .single_ended(single_ended), .pwr_sel(pwr_sel), .ref_diff(ref_diff)
    );

    always #5 dclk = ~dclk; // 100 MHz

    int n_chk = 0;
    int n_bad = 0;

    int          starts [NF];
    logic [11:0] vals   [NF];
    logic        din_a  [MAXS];
    logic        dout_e [MAXS];
    logic        busy_e [MAXS];
    logic        acq_e  [MAXS];
    logic [11:0] ain_a  [MAXS];
    int          fr_at  [MAXS];
    string       dtag   [MAXS];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One rising and one falling edge; returns 2 units after the falling edge.
    task automatic step(input logic d);
        din = d;
        @(posedge dclk);
        @(negedge dclk);
        #2;
    endtask

    function automatic logic plate(input logic [2:0] c);
        return (c == 3'b001) || (c == 3'b011) || (c == 3'b100) || (c == 3'b101);
    endfunction

    task automatic single_frame(input logic [7:0] b, input logic [11:0] v, input string tag);
        int nb;
        nb = b[3] ? 8 : 12;
        for (int o = 0; o < 24; o++) begin
            logic ed;
            ain = (o <= 7) ? v : ~v;
            step((o < 8) ? b[7-o] : 1'b0);
            ed = (o >= 8 && (o - 8) < nb) ? v[11-(o-8)] : 1'b0;
            check({tag, " dout"}, dout, ed);
            check({tag, " R7 busy"}, busy, (o == 7));
            check({tag, " R6 acq"}, acq_active, (o >= 4 && o <= 6));
            if (o == 7) begin
                check({tag, " R4 chan"}, ch_sel, b[6:4]);
                check({tag, " R4 res"}, short_res, b[3]);
                check({tag, " R5 ref_diff"}, ref_diff, !b[2] && plate(b[6:4]));
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_up();
    end

    initial begin
        int pos, total;

        // R1: reset state
        repeat (3) @(negedge dclk);
        #2;
        check("R1 dout", dout, 0);
        check("R1 busy", busy, 0);
        check("R1 acq", acq_active, 0);
        check("R1 chan", ch_sel, 0);
        check("R1 fields", {short_res, single_ended, pwr_sel, ref_diff}, 0);
        check("R1 dout_en", dout_en, 0);
        check("R1 busy_en", busy_en, 0);
        rst_n = 1'b1;

        // R2: deselected activity is ignored
        for (int k = 0; k < 16; k++) begin
            step(((8'hDD >> (k % 8)) & 1) != 0);
            check("R2 dout_en", dout_en, 0);
            check("R2 busy_en", busy_en, 0);
            check("R2 busy", busy, 0);
            check("R2 acq", acq_active, 0);
            check("R2 fields", {ch_sel, short_res, single_ended, pwr_sel}, 0);
        end

        // Build the overlapped sweep over all 128 command bytes
        for (int k = 0; k < MAXS; k++) begin
            din_a[k]  = 1'b0;
            dout_e[k] = 1'b0;
            busy_e[k] = 1'b0;
            acq_e[k]  = 1'b0;
            ain_a[k]  = 12'((k * 2654) ^ 12'h9C3);
            fr_at[k]  = -1;
            dtag[k]   = "R11 gap";
        end
        pos = 4; // three leading zeros exercise R3
        for (int f = 0; f < NF; f++) begin
            starts[f] = pos;
            pos += (f % 3 == 0) ? 24 : 16;
        end
        total = starts[NF-1] + 28;
        for (int f = 0; f < NF; f++) begin
            logic [7:0] b;
            int s, nb, sp;
            s  = starts[f];
            b  = {1'b1, 7'(f)};
            nb = b[3] ? 8 : 12;
            sp = (f < NF - 1) ? starts[f+1] - s : 24;
            vals[f] = (f == 5) ? 12'hFFF : (f == 6) ? 12'h000 : 12'(f * 1237 + 91);
            for (int i = 0; i < 8; i++) begin
                din_a[s+i] = b[7-i];
                ain_a[s+i] = vals[f];
            end
            busy_e[s+7] = 1'b1;
            for (int i = 4; i <= 6; i++) acq_e[s+i] = 1'b1;
            for (int j = 0; j < nb; j++) begin
                dout_e[s+8+j] = vals[f][11-j];
                if (nb == 8)                 dtag[s+8+j] = "R9 R10 bits";
                else if (sp == 16 && j >= 8) dtag[s+8+j] = "R11 R8 overlap bits";
                else                         dtag[s+8+j] = "R8 R10 bits";
            end
            if (nb == 8) for (int j = 8; j < 12; j++) dtag[s+8+j] = "R9 tail";
            fr_at[s+7] = f;
        end

        cs_n = 1'b0;
        for (int k = 1; k <= total; k++) begin
            ain = ain_a[k];
            step(din_a[k]);
            check(dtag[k], dout, dout_e[k]);
            check("R7 busy", busy, busy_e[k]);
            check("R6 acq", acq_active, acq_e[k]);
            check("R2 enables", {dout_en, busy_en}, 2'b11);
            if (fr_at[k] >= 0) begin
                logic [7:0] b;
                b = {1'b1, 7'(fr_at[k])};
                check("R3 R4 chan", ch_sel, b[6:4]);
                check("R4 res", short_res, b[3]);
                check("R4 ref sel", single_ended, b[2]);
                check("R4 pwr", pwr_sel, b[1:0]);
                check("R5 ref_diff", ref_diff, !b[2] && plate(b[6:4]));
            end
        end

        // R12: abort during readout
        begin
            logic [7:0] b;
            b = 8'b1_101_0_1_00;
            for (int o = 0; o < 12; o++) begin
                ain = 12'hABC;
                step((o < 8) ? b[7-o] : 1'b0);
            end
        end
        cs_n = 1'b1;
        step(1'b0);
        check("R12 dout after abort", dout, 0);
        check("R12 busy after abort", busy, 0);
        step(1'b1);
        cs_n = 1'b0;
        for (int k = 0; k < 20; k++) begin
            step(1'b0);
            check("R12 dout idle", dout, 0);
            check("R12 busy idle", busy, 0);
            check("R12 acq idle", acq_active, 0);
        end

        // R12: abort during command capture; partial byte discarded
        step(1'b1); step(1'b0); step(1'b1); step(1'b1);
        cs_n = 1'b1;
        step(1'b1);
        step(1'b1);
        cs_n = 1'b0;
        for (int k = 0; k < 16; k++) begin
            step(1'b0);
            check("R12 busy", busy, 0);
            check("R12 acq", acq_active, 0);
        end
        check("R12 chan kept", ch_sel, 3'b101);
        check("R12 fields kept", {short_res, single_ended, pwr_sel}, 4'b0100);

        // Full frames after recovery: 8-bit Y ratiometric, 12-bit aux single-ended
        single_frame(8'b1_001_1_0_01, 12'h5E7, "R9 R12");
        check("R5 Y diff", ref_diff, 1);
        single_frame(8'b1_110_0_0_10, 12'h3A6, "R8 R10");
        check("R5 aux forced single", ref_diff, 0);

        cs_n = 1'b1;
        step(1'b0);
        check("R2 dout_en final", dout_en, 0);
        finish_up();
    end
endmodule